// File: doc/BRIEF.md
# Predicated Element-Width Register Write Port

This block is the write side of a small register file whose rows are 64 bits wide and are handled as byte-addressable storage. Vector results arrive already packed, together with one predicate bit for each element. The element width is selected per write: 8, 16, 32 or 64 bits. Each predicate bit is copied onto as many byte write enables as its element has bytes. A masked-off element, or a byte outside the write, therefore keeps its old contents, and no register is ever read back, merged and rewritten.

A write names a destination register and a starting element offset measured from byte 0 of that register. Up to eight bytes of packed element data are taken in one cycle. When the offset is not row-aligned, the run spills into the next-numbered register. The byte enables for the two rows are worked out separately. A combinational read port returns any row for inspection.

Top module: `pred_ew_wrport`

## Requirements
- R1: While reset is active, and after it is released, every row reads as zero until the first write lands.
- R2: `wr_ew` encodes the element width as 0 = 8 bits, 1 = 16 bits, 2 = 32 bits and 3 = 64 bits. Element i lies at bits [i*W +: W] of `wr_data` and is qualified by `wr_mask[i]`.
- R3: At 8-bit width, each mask bit enables exactly one byte.
- R4: At 64-bit width, `wr_mask[0]` alone decides whether the whole row is written or kept.
- R5: At 16-bit or 32-bit width, each mask bit is copied onto 2 or 4 consecutive byte enables. All other bytes of the row, including those of masked-off elements, keep their values.
- R6: The first data byte lands at byte `wr_off`*W/8, counted from byte 0 of register `wr_reg`. Later bytes continue upward, and a run that crosses the row's top byte continues in register `wr_reg`+1. Register numbers wrap modulo the register count.
- R7: A write whose effective mask is all zero, or a cycle with `wr_en` low, leaves every row unchanged.
- R8: `rd_data` is combinational on `rd_idx`. A write is visible from the cycle after the clock edge that accepts it.
- R9: An enabled byte takes exactly its data byte. Mask bits at or above the element count for the width (64/W) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset that clears all rows |
| wr_en | input | 1 | Write strobe |
| wr_reg | input | log2(NREGS) | Destination register index |
| wr_ew | input | 2 | Element width select |
| wr_off | input | 3 | Starting element offset from byte 0 of the destination |
| wr_data | input | 64 | Packed element results, element 0 lowest |
| wr_mask | input | 8 | Per-element predicate bits |
| rd_idx | input | log2(NREGS) | Read row index |
| rd_data | output | 64 | Current contents of row `rd_idx` |

## Verification
Directed writes cover each width with sparse masks. These show whether predicate copying picks the right bytes at each width. Partial 16-bit writes land on a pre-filled row and tell a correct byte-enable path apart from one that clears or rewrites neighbouring bytes. Non-aligned offsets near the top register, and across the last row, separate correct spill and wrap from writes that are dropped or sent to the wrong row. Long pseudo-random runs, checked against a byte-level model row by row on every cycle, catch errors in steering or mask handling that the directed cases miss.

// File: rtl/pred_ew_wrport.sv
module pred_ew_wrport #(
  parameter int NREGS = 8,
  localparam int RW = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_reg,
  input  logic [1:0]    wr_ew,
  input  logic [2:0]    wr_off,
  input  logic [63:0]   wr_data,
  input  logic [7:0]    wr_mask,
  input  logic [RW-1:0] rd_idx,
  output logic [63:0]   rd_data
);

  logic [63:0]   rows [NREGS];
  logic [7:0]    elem_lim, mask_v, be8;
  logic [5:0]    start_b;
  logic [2:0]    lane;
  logic [15:0]   be16;
  logic [127:0]  d128;
  logic [RW-1:0] lo_row, hi_row;

  always_comb begin
    case (wr_ew)
      2'd0:    elem_lim = 8'hFF;
      2'd1:    elem_lim = 8'h0F;
      2'd2:    elem_lim = 8'h03;
      default: elem_lim = 8'h01;
    endcase
  end

  assign mask_v = wr_mask & elem_lim;

  for (genvar j = 0; j < 8; j++) begin : g_rep
    assign be8[j] = mask_v[3'(j) >> wr_ew];
  end

  assign start_b = {3'b000, wr_off} << wr_ew;
  assign lane    = start_b[2:0];
  assign be16    = {8'h00, be8} << lane;
  assign d128    = {64'h0, wr_data} << {lane, 3'b000};
  assign lo_row  = wr_reg + RW'(start_b[5:3]);
  assign hi_row  = lo_row + RW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREGS; r++) rows[r] <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < 8; b++) begin
        if (be16[b])   rows[lo_row][b*8 +: 8] <= d128[b*8 +: 8];
        if (be16[b+8]) rows[hi_row][b*8 +: 8] <= d128[64 + b*8 +: 8];
      end
    end
  end

  assign rd_data = rows[rd_idx];

  // R4
  ew64_full_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ew == 2'd3) |-> ((be16[7:0] == 8'h00 || be16[7:0] == 8'hFF) && be16[15:8] == 8'h00));

  // R5
  enable_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($countones(be16) == ($countones(wr_mask & elem_lim) << wr_ew)));

  for (genvar r = 0; r < NREGS; r++) begin : g_row
    for (genvar b = 0; b < 8; b++) begin : g_byte
      // R7
      untouched_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && ((lo_row == RW'(r) && be16[b]) || (hi_row == RW'(r) && be16[b+8])))
        |=> $stable(rows[r][b*8 +: 8]));
    end
  end

  for (genvar b = 0; b < 8; b++) begin : g_dat
    // R9
    written_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && be16[b]) |=> (rows[$past(lo_row)][b*8 +: 8] == $past(d128[b*8 +: 8])));
  end

endmodule

// File: tb/pred_ew_wrport_tb.sv
module pred_ew_wrport_tb_top;
  localparam int PERIOD = 10;
  localparam int NREGS  = 8;
  localparam int RW     = $clog2(NREGS);

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [RW-1:0] wr_reg = '0, rd_idx = '0;
  logic [1:0] wr_ew = '0;
  logic [2:0] wr_off = '0;
  logic [63:0] wr_data = '0, rd_data;
  logic [7:0] wr_mask = '0;

  int checks = 0, fails = 0;
  bit hold = 1;
  string cur_req = "R1";
  logic [7:0] model [NREGS*8];

  pred_ew_wrport #(.NREGS(NREGS)) dut_i (.*);

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [63:0] mrow(int r);
    logic [63:0] v;
    for (int b = 0; b < 8; b++) v[b*8 +: 8] = model[r*8 + b];
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS*8; i++) model[i] = 8'h00;
    end else if (wr_en) begin
      int eb, n, base;
      eb = 1 << wr_ew;
      n = 8 >> wr_ew;
      base = int'(wr_reg) * 8 + int'(wr_off) * eb;
      for (int i = 0; i < n; i++)
        if (wr_mask[i])
          for (int k = 0; k < eb; k++)
            model[(base + i*eb + k) % (NREGS*8)] = wr_data[(i*eb + k)*8 +: 8];
    end
  end

  // R8: every-cycle comparison of one row against the model
  always @(negedge clk) begin
    if (rst_n && !hold) begin
      checks++;
      if (rd_data !== mrow(int'(rd_idx))) begin
        fails++;
        $display("FAIL %s row %0d: got %h expected %h", cur_req, rd_idx, rd_data, mrow(int'(rd_idx)));
      end
      rd_idx <= rd_idx + 1'b1;
    end
  end

  task automatic do_write(input int r, input int ew, input int off, input logic [63:0] d, input logic [7:0] m);
    @(negedge clk);
    wr_en = 1; wr_reg = RW'(r); wr_ew = 2'(ew); wr_off = 3'(off); wr_data = d; wr_mask = m;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic expect_row(input int r, input logic [63:0] exp, input string req);
    hold = 1;
    @(negedge clk);
    rd_idx = RW'(r);
    #1;
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s row %0d: got %h expected %h", req, r, rd_data, exp);
    end
    hold = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(PERIOD*100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    lf = 32'h1ACE_B00C;
    #1;
    for (int r = 0; r < NREGS; r++) begin
      rd_idx = RW'(r); #1;
      checks++;
      if (rd_data !== 64'h0) begin
        fails++; $display("FAIL R1 row %0d in reset: got %h expected 0", r, rd_data);
      end
    end
    idle(2);
    rst_n = 1;
    for (int r = 0; r < NREGS; r++) expect_row(r, 64'h0, "R1");

    cur_req = "R4";
    do_write(2, 3, 0, 64'hAAAA_AAAA_AAAA_AAAA, 8'h01);
    expect_row(2, 64'hAAAA_AAAA_AAAA_AAAA, "R4");
    do_write(3, 3, 0, 64'h1122_3344_5566_7788, 8'h01);
    do_write(2, 3, 0, 64'h5555_5555_5555_5555, 8'h00);
    expect_row(2, 64'hAAAA_AAAA_AAAA_AAAA, "R4");

    cur_req = "R5";
    do_write(2, 1, 4, 64'h0000_0000_0000_BEEF, 8'h01);
    expect_row(3, 64'h1122_3344_5566_BEEF, "R5");
    expect_row(2, 64'hAAAA_AAAA_AAAA_AAAA, "R5");
    do_write(2, 1, 0, 64'h4444_3333_2222_1111, 8'h05);
    expect_row(2, 64'hAAAA_3333_AAAA_1111, "R5");
    do_write(5, 2, 1, 64'h1234_5678_CAFE_F00D, 8'h01);
    expect_row(5, 64'hCAFE_F00D_0000_0000, "R5 R2");

    cur_req = "R3";
    do_write(4, 0, 0, 64'h7777_7777_7777_7777, 8'h81);
    expect_row(4, 64'h7700_0000_0000_0077, "R3");

    cur_req = "R6";
    do_write(6, 0, 5, 64'h0807_0605_0403_0201, 8'hFF);
    expect_row(6, 64'h0302_0100_0000_0000, "R6");
    expect_row(7, 64'h0000_0008_0706_0504, "R6");
    do_write(7, 2, 3, 64'hBBBB_BBBB_DDDD_DDDD, 8'h03);
    expect_row(0, 64'hDDDD_DDDD_0000_0000, "R6 wrap");
    expect_row(1, 64'h0000_0000_BBBB_BBBB, "R6 wrap");

    cur_req = "R7";
    do_write(0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00);
    expect_row(0, 64'hDDDD_DDDD_0000_0000, "R7");
    @(negedge clk); wr_reg = '0; wr_data = '1; wr_mask = 8'hFF; wr_ew = 0;
    @(negedge clk);
    expect_row(0, 64'hDDDD_DDDD_0000_0000, "R7 wr_en low");

    cur_req = "R9";
    do_write(4, 3, 0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFE);
    expect_row(4, 64'h7700_0000_0000_0077, "R9");
    do_write(1, 2, 0, 64'h9999_9999_8888_8888, 8'hFD);
    expect_row(1, 64'h0000_0000_8888_8888, "R9");

    cur_req = "R2";
    hold = 0;
    for (int t = 0; t < 400; t++) begin
      logic [63:0] d;
      logic [7:0] m;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      d[31:0] = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      d[63:32] = lf;
      m = lf[7:0] ^ lf[23:16];
      do_write(int'(lf[10:8]), int'(lf[13:12]), int'(lf[18:16]), d, m);
      idle(t % 3 == 0 ? NREGS : 1);
    end
    idle(NREGS + 2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule